// File: doc/BRIEF.md
# Dual-Mode MCU Parallel Register Interface

This block is the slave side of an 8-bit microcontroller parallel bus. It exposes a bank of 77 internal 8-bit registers to the microcontroller. A static mode input picks one of two bus styles. In multiplexed mode, a shared bidirectional bus first carries the low address byte, which an address strobe captures, and then carries data. A separate 8-bit input supplies the high address byte. In non-multiplexed mode, that separate 8-bit input is the whole address and the shared bus carries data only.

The chip select and the active-low write and read strobes each pass through a two-flop synchronizer before the block acts on them. A write lands only after the synchronized write condition has been seen on three consecutive clocks. The data and the address used by the write travel through the same two-stage delay, so they line up with the strobes. A read drives the addressed register onto the shared bus while the synchronized read condition holds and the address is inside the window. At every other time the bus is left floating.

Top module: `mcu_regbank_if`

## Requirements
- R1: While reset is low, every register, the captured low address byte and the strobe synchronizers clear to zero or to their idle state. After reset the data bus is not driven and every register reads 0x00.
- R2: With mode 0 latched, a clock edge that sees the address strobe high stores the data bus into the low address byte. The register address is {high byte, low byte}, and registers 0x8000 to 0x804C are readable and writable at offsets 0x00 to 0x4C.
- R3: With mode 0 latched, an address whose high byte is not 0x80, or whose low byte is above 0x4C, is outside the window. A write to it changes no register, including offset 0x00, and a read of it leaves the bus undriven.
- R4: With mode 1 latched, the 8-bit address input alone is the register offset, and values 0x00 to 0x4C are in the window. Values above 0x4C are ignored for both writes and reads, and the address strobe has no effect on which register is accessed.
- R5: A write fires when the synchronized chip select is 1, write is 0 and read is 1 on three consecutive clocks. A pulse that lasts three or more raw clocks updates the register exactly once.
- R6: A write pulse seen on only two clocks updates no register.
- R7: The bus is driven only while the synchronized chip select is 1, read is 0 and write is 1 and the address is in the window. With both strobes low, the block neither drives the bus nor writes.
- R8: The mode input is sampled only while reset is low. Changing it afterwards has no effect until the next reset.
- R9: With chip select at 0, a low write strobe updates no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset; the mode input is sampled while it is low |
| mode_sel | input | 1 | Bus style: 0 = multiplexed with 16-bit window, 1 = separate 8-bit address |
| cs | input | 1 | Chip select, active high |
| wr_n | input | 1 | Write strobe, active low |
| rd_n | input | 1 | Read strobe, active low |
| ale | input | 1 | Low-address capture strobe (mode 0 only) |
| addr_hi | input | 8 | High address byte in mode 0, full offset in mode 1 |
| data_io | inout | 8 | Shared address/data bus in mode 0, data bus in mode 1 |

## Verification
The bound checker checks four rules on every clock. The bus is never driven outside a synchronized read condition. A write fires only after the write condition has been seen on the two clocks before it. Two writes never fire back to back from one pulse. The latched mode never moves outside reset. Only the bench scenarios can show the window boundaries in both modes (0x4C against 0x4D, and high bytes other than 0x80), the absence of aliasing onto offset 0x00, that a two-clock pulse is rejected, that chip select gates writes, and that the mode changes only after a reset.

// File: rtl/mcu_regbank_if.sv
module mcu_regbank_if #(
  parameter int NREG      = 77,
  parameter int DW        = 8,
  parameter int WR_CYCLES = 3,
  parameter logic [7:0] BASE_HI = 8'h80
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_sel,
  input  logic          cs,
  input  logic          wr_n,
  input  logic          rd_n,
  input  logic          ale,
  input  logic [7:0]    addr_hi,
  inout  wire  [DW-1:0] data_io
);
  localparam int OW = $clog2(NREG);
  localparam int CW = $clog2(WR_CYCLES + 1);

  logic [DW-1:0] regs [NREG];
  logic          mode_q;
  logic [7:0]    lo_q;
  logic [1:0]    cs_s, wrn_s, rdn_s;
  logic [DW-1:0] d1, d2;
  logic [OW-1:0] o1, o2;
  logic          w1, w2;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk)
    if (!rst_n) mode_q <= mode_sel;

  wire           in_win = mode_q ? (addr_hi < 8'(NREG))
                                 : (addr_hi == BASE_HI && lo_q < 8'(NREG));
  wire [OW-1:0]  off    = mode_q ? addr_hi[OW-1:0] : lo_q[OW-1:0];
  wire           wr_ok  = cs_s[1] & ~wrn_s[1] & rdn_s[1];
  wire           rd_ok  = cs_s[1] & ~rdn_s[1] & wrn_s[1];
  wire           wr_fire = wr_ok && w2 && (cnt == CW'(WR_CYCLES - 1));
  wire           drive_en = rd_ok & in_win;

  assign data_io = drive_en ? regs[off] : 'z;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cs_s  <= '0;
      wrn_s <= '1;
      rdn_s <= '1;
      lo_q  <= '0;
      d1 <= '0; d2 <= '0;
      o1 <= '0; o2 <= '0;
      w1 <= 1'b0; w2 <= 1'b0;
      cnt <= '0;
    end else begin
      cs_s  <= {cs_s[0], cs};
      wrn_s <= {wrn_s[0], wr_n};
      rdn_s <= {rdn_s[0], rd_n};
      if (ale && !mode_q) lo_q <= data_io;
      d1 <= data_io; d2 <= d1;
      o1 <= off;     o2 <= o1;
      w1 <= in_win;  w2 <= w1;
      if (!wr_ok) cnt <= '0;
      else if (cnt != CW'(WR_CYCLES)) cnt <= cnt + 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (wr_fire) begin
      regs[o2] <= d2;
    end
endmodule

// File: rtl/mcu_regbank_if_chk.sv
module mcu_regbank_if_chk (
  input logic clk,
  input logic rst_n,
  input logic cs,
  input logic wr_n,
  input logic rd_n,
  input logic drive_en,
  input logic wr_fire,
  input logic mode_q
);
  logic c_a, c_b, w_a, w_b, r_a, r_b;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      c_a <= 1'b0; c_b <= 1'b0;
      w_a <= 1'b1; w_b <= 1'b1;
      r_a <= 1'b1; r_b <= 1'b1;
    end else begin
      c_a <= cs;   c_b <= c_a;
      w_a <= wr_n; w_b <= w_a;
      r_a <= rd_n; r_b <= r_a;
    end

  wire rd_seen = c_b & ~r_b & w_b;
  wire wr_seen = c_b & ~w_b & r_b;

  p_no_drive_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_seen |-> !drive_en);
  p_write_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |-> (wr_seen && $past(wr_seen, 1) && $past(wr_seen, 2)));
  p_single_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |=> !wr_fire);
  p_mode_static_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(mode_q));
endmodule

bind mcu_regbank_if mcu_regbank_if_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs(cs), .wr_n(wr_n), .rd_n(rd_n),
  .drive_en(drive_en), .wr_fire(wr_fire), .mode_q(mode_q)
);

// File: tb/mcu_regbank_if_test.sv
`timescale 1ns/1ps
module mcu_regbank_if_test;
  logic clk = 0, rst_n = 0, mode_sel = 1, cs = 0, wr_n = 1, rd_n = 1, ale = 0;
  logic [7:0] addr_hi = 0, drv = 0;
  logic drv_en = 0;
  wire  [7:0] bus;
  int checks = 0, fails = 0;
  bit done = 0;

  for (genvar i = 0; i < 8; i++) begin : g_pu
    pullup (bus[i]);
  end
  assign bus = drv_en ? drv : 8'bz;

  always #4 clk = ~clk;

  mcu_regbank_if uut (.clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .cs(cs),
    .wr_n(wr_n), .rd_n(rd_n), .ale(ale), .addr_hi(addr_hi), .data_io(bus));

  // {offset, write data, expected read}; 0xFF means bus left floating (pulled up)
  localparam logic [23:0] VEC [6] = '{
    {8'h00, 8'h5A, 8'h5A}, {8'h4C, 8'hA5, 8'hA5}, {8'h4D, 8'h33, 8'hFF},
    {8'h80, 8'h44, 8'hFF}, {8'h27, 8'hC3, 8'hC3}, {8'h10, 8'h01, 8'h01}};

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic m);
    mode_sel = m; rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic latch_lo(input logic [7:0] lo);
    drv = lo; drv_en = 1; ale = 1;
    @(negedge clk);
    ale = 0; drv_en = 0;
  endtask

  task automatic bus_wr(input logic [7:0] hi, input logic [7:0] d, input int len,
                        input logic sel);
    addr_hi = hi; drv = d; drv_en = 1; cs = sel; wr_n = 0;
    repeat (len) @(negedge clk);
    wr_n = 1; cs = 0; drv_en = 0;
    repeat (4) @(negedge clk);
  endtask

  task automatic bus_rd(input logic [7:0] hi, output logic [7:0] v);
    addr_hi = hi; cs = 1; rd_n = 0;
    repeat (3) @(negedge clk);
    v = bus;
    cs = 0; rd_n = 1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    logic [7:0] v;
    do_reset(1'b1);
    chk("R1 idle bus", bus, 8'hFF);
    bus_rd(8'h00, v); chk("R1 reg0 cleared", v, 8'h00);
    bus_rd(8'h4C, v); chk("R1 reg4C cleared", v, 8'h00);

    for (int i = 0; i < 6; i++) begin
      bus_wr(VEC[i][23:16], VEC[i][15:8], 3, 1'b1);
      bus_rd(VEC[i][23:16], v);
      chk("R4/R5 mode1 vector", v, VEC[i][7:0]);
    end
    bus_rd(8'h00, v); chk("R4 no alias onto 0x00", v, 8'h5A);

    latch_lo(8'h4D);
    bus_wr(8'h02, 8'h6E, 3, 1'b1);
    bus_rd(8'h02, v); chk("R4 strobe ignored in mode1", v, 8'h6E);

    bus_wr(8'h03, 8'h99, 6, 1'b1);
    bus_rd(8'h03, v); chk("R5 long pulse", v, 8'h99);
    bus_wr(8'h04, 8'h77, 2, 1'b1);
    bus_rd(8'h04, v); chk("R6 short pulse", v, 8'h00);
    bus_wr(8'h05, 8'h21, 4, 1'b0);
    bus_rd(8'h05, v); chk("R9 cs low", v, 8'h00);

    addr_hi = 8'h03; cs = 1; wr_n = 0; rd_n = 0;
    repeat (4) @(negedge clk);
    chk("R7 both strobes no drive", bus, 8'hFF);
    cs = 0; wr_n = 1; rd_n = 1;
    repeat (4) @(negedge clk);
    bus_rd(8'h03, v); chk("R7 both strobes no write", v, 8'h99);

    mode_sel = 0;
    bus_wr(8'h06, 8'h3C, 3, 1'b1);
    bus_rd(8'h06, v); chk("R8 mode held until reset", v, 8'h3C);

    do_reset(1'b0);
    bus_rd(8'h80, v); chk("R1/R8 mode0 after reset", v, 8'h00);
    latch_lo(8'h00); bus_wr(8'h80, 8'h11, 3, 1'b1);
    bus_rd(8'h80, v); chk("R2 0x8000", v, 8'h11);
    latch_lo(8'h4C); bus_wr(8'h80, 8'hB4, 3, 1'b1);
    bus_rd(8'h80, v); chk("R2 0x804C", v, 8'hB4);
    latch_lo(8'h4D); bus_wr(8'h80, 8'h55, 3, 1'b1);
    bus_rd(8'h80, v); chk("R3 0x804D floats", v, 8'hFF);
    latch_lo(8'h00); bus_wr(8'h81, 8'h66, 3, 1'b1);
    bus_rd(8'h81, v); chk("R3 0x8100 floats", v, 8'hFF);
    bus_rd(8'h80, v); chk("R3 0x8000 untouched", v, 8'h11);
    latch_lo(8'h0D);
    bus_rd(8'h80, v); chk("R3 no alias at 0x800D", v, 8'h00);
    latch_lo(8'h07); bus_wr(8'h80, 8'h08, 2, 1'b1);
    bus_rd(8'h80, v); chk("R6 mode0 short pulse", v, 8'h00);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule